// File: doc/BRIEF.md
# Serial Word Receiver with Held Output

This block assembles a serial bit stream into parallel words. Each accepted bit moves through a chain of stage flip-flops. A shift counter decides when a word is complete; the data itself is never inspected. On the edge that accepts the last bit of a word, the finished word is also copied into a separate holding register. The next word can then shift in while the held value stays steady for downstream logic.

The bit order is selectable. With `msb_first` high, each new bit enters at bit 0 and older bits move toward the top, so the first bit received ends in the most significant position. With `msb_first` low, each new bit enters at the top and older bits move down, so the first bit ends in bit 0. When `async_sel` is high, the serial input comes from a foreign clock domain and passes through two synchronizing flip-flops first. When it is low, the input is used directly.

Control is a two-state machine. `RX_IDLE` means no bits of a word have been taken yet. `RX_FILL` means a partial word is present. The transitions are:

- **start**: `RX_IDLE` to `RX_FILL` on an accepted shift.
- **finish**: `RX_FILL` to `RX_IDLE` on the shift that completes the word.
- **abort**: either state to `RX_IDLE` on `clr`.

Top module: `ser_word_rx`

## Requirements
- R1: While `rst_n` is low, `stage_q`, `word_q` and `word_vld` are all zero, and the synchronizer flops are cleared.
- R2: With `msb_first`=1, an accepted shift moves `stage_q[W-2:0]` up one place and puts the new bit in bit 0, so the first of W bits ends in bit W-1.
- R3: With `msb_first`=0, an accepted shift moves `stage_q[W-1:1]` down one place and puts the new bit in bit W-1, so the first of W bits ends in bit 0.
- R4: A shift is accepted on a rising edge where `shift_en`=1 and `clr`=0, and `stage_q` shows the result right after that edge.
- R5: `word_vld` is high for exactly one cycle, directly after the W-th accepted shift counted since reset, clear or the previous completed word. The count wraps to zero on that same edge.
- R6: `word_q` takes the completed word on the same edge that raises `word_vld`. It then holds that value through later shifts until the next word completes.
- R7: With `shift_en`=0, both `stage_q` and the shift count hold, whatever `ser_in` does.
- R8: `clr`=1 zeroes `stage_q`, the shift count and `word_vld` on the next edge, and takes priority over `shift_en`; `word_q` is unchanged.
- R9: With `async_sel`=1, the bit taken by a shift is the `ser_in` value sampled two edges before that shift edge. With `async_sel`=0, it is the `ser_in` value at the shift edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data bit |
| shift_en | input | 1 | Accept one bit on this edge |
| msb_first | input | 1 | 1: first bit lands in MSB; 0: first bit lands in LSB |
| clr | input | 1 | Synchronous clear of stages, count and strobe |
| async_sel | input | 1 | 1: route `ser_in` through the two-flop synchronizer |
| stage_q | output | WORD_W | Live stage contents |
| word_q | output | WORD_W | Held copy of the last completed word |
| word_vld | output | 1 | One-cycle strobe: a new word is in `word_q` |

## Verification
`stage_q`, `word_q` and `word_vld` all change on the edge that accepts a bit, so each is due one edge after the stimulus. In synchronized mode, `ser_in` must be stable two edges before the shift edge that uses it. The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the edge it checks. In synchronized mode it keeps each bit stable for two edges before raising `shift_en`. One directed case changes `ser_in` on the shift edge itself, to show that the bit taken is the older value.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_FILL = 1'b1
    } rx_state_e;
endpackage

// File: rtl/ser_rx_sync.sv
// Optional input synchronizer: a chain of flops on the shift clock,
// bypassed when the source already shares the clock.
module ser_rx_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    input  logic async_sel,
    output logic bit_out
);
    logic [SYNC_STAGES-1:0] sync_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ser_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign bit_out = async_sel ? sync_q[SYNC_STAGES-1] : ser_in;
endmodule

// File: rtl/ser_rx_shifter.sv
// Stage chain with direction chosen by bit order; exposes the next value
// so the holding register can capture a word on its final shift edge.
module ser_rx_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              msb_first,
    input  logic              bit_in,
    output logic [WORD_W-1:0] stage_q,
    output logic [WORD_W-1:0] stage_nxt
);
    logic [WORD_W-1:0] shifted;

    always_comb begin
        if (msb_first) shifted = {stage_q[WORD_W-2:0], bit_in};
        else           shifted = {bit_in, stage_q[WORD_W-1:1]};
    end

    always_comb begin
        if (clr)           stage_nxt = '0;
        else if (shift_en) stage_nxt = shifted;
        else               stage_nxt = stage_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_nxt;
    end
endmodule

// File: rtl/ser_rx_ctrl.sv
// Word framing by shift count: state register, next-state logic and
// a registered output process for the completion strobe.
module ser_rx_ctrl
    import ser_rx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift_en,
    output logic load_word,
    output logic word_vld
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;

    assign accept    = shift_en && !clr;
    assign load_word = accept && (cnt_q == LAST);

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RX_IDLE: begin
                if (accept) begin           // start
                    state_d = RX_FILL;
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            RX_FILL: begin
                if (load_word) begin        // finish
                    state_d = RX_IDLE;
                    cnt_d   = '0;
                end else if (accept) begin
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = RX_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (clr) begin                      // abort
            state_d = RX_IDLE;
            cnt_d   = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_vld <= 1'b0;
        else        word_vld <= load_word;
    end
endmodule

// File: rtl/ser_rx_latch.sv
// Holding register for the last completed word.
module ser_rx_latch #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/ser_word_rx.sv
module ser_word_rx #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              shift_en,
    input  logic              msb_first,
    input  logic              clr,
    input  logic              async_sel,
    output logic [WORD_W-1:0] stage_q,
    output logic [WORD_W-1:0] word_q,
    output logic              word_vld
);
    logic              bit_sel;
    logic              load_word;
    logic [WORD_W-1:0] stage_nxt;

    initial begin
        if (WORD_W < 2)      $error("WORD_W must be at least 2");
        if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
    end

    ser_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
        .async_sel(async_sel), .bit_out(bit_sel)
    );

    ser_rx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
        .msb_first(msb_first), .bit_in(bit_sel),
        .stage_q(stage_q), .stage_nxt(stage_nxt)
    );

    ser_rx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift_en),
        .load_word(load_word), .word_vld(word_vld)
    );

    ser_rx_latch #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(load_word),
        .d(stage_nxt), .q(word_q)
    );
endmodule

// File: rtl/ser_word_rx_chk.sv
module ser_word_rx_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_in,
    input logic              shift_en,
    input logic              msb_first,
    input logic              clr,
    input logic              async_sel,
    input logic [WORD_W-1:0] stage_q,
    input logic [WORD_W-1:0] word_q,
    input logic              word_vld
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    // independent shift tally from the port signals
    logic [CW-1:0] m_cnt;
    logic          m_vld;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= '0;
            m_vld <= 1'b0;
        end else if (clr) begin
            m_cnt <= '0;
            m_vld <= 1'b0;
        end else if (shift_en) begin
            m_vld <= (int'(m_cnt) == WORD_W - 1);
            m_cnt <= (int'(m_cnt) == WORD_W - 1) ? '0 : m_cnt + 1'b1;
        end else begin
            m_vld <= 1'b0;
        end
    end

    always_comb begin
        if (!rst_n) AST_RESET_CLEAR: assert (stage_q == '0 && word_q == '0 && !word_vld); // R1
    end

    AST_MSB_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr && msb_first) |=> stage_q[WORD_W-1:1] == $past(stage_q[WORD_W-2:0])); // R2
    AST_LSB_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr && !msb_first) |=> stage_q[WORD_W-2:0] == $past(stage_q[WORD_W-1:1])); // R3
    AST_VLD_BY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld == m_vld); // R5
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R5
    AST_WORD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> word_q == stage_q); // R6
    AST_WORD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_q)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clr) |=> $stable(stage_q) && !word_vld); // R7
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> stage_q == '0 && !word_vld && $stable(word_q)); // R8
endmodule

bind ser_word_rx ser_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
    .msb_first(msb_first), .clr(clr), .async_sel(async_sel),
    .stage_q(stage_q), .word_q(word_q), .word_vld(word_vld)
);

// File: tb/tb_ser_word_rx.sv
module tb_ser_word_rx;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, ser_in, shift_en, msb_first, clr, async_sel;
    logic [W-1:0] stage_q, word_q;
    logic         word_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ser_word_rx #(.WORD_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
        .msb_first(msb_first), .clr(clr), .async_sel(async_sel),
        .stage_q(stage_q), .word_q(word_q), .word_vld(word_vld)
    );

    // {async_sel, msb_first, word}
    localparam logic [W+1:0] VEC [0:7] = '{
        {1'b0, 1'b1, 8'hA5}, {1'b0, 1'b0, 8'h1C},
        {1'b0, 1'b1, 8'h3C}, {1'b0, 1'b0, 8'h4B},
        {1'b1, 1'b1, 8'h6E}, {1'b1, 1'b0, 8'hD2},
        {1'b0, 1'b1, 8'hFF}, {1'b0, 1'b0, 8'h00}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // shift one bit; begins and ends just after a falling edge
    task automatic put_bit(input logic b, input logic sync_mode);
        ser_in = b;
        if (sync_mode) begin
            shift_en = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic send_word(input logic [W-1:0] w, input logic msb, input logic sync_mode);
        msb_first = msb;
        async_sel = sync_mode;
        for (int i = 0; i < W; i++)
            put_bit(msb ? w[W-1-i] : w[i], sync_mode);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; ser_in = 1'b1; shift_en = 1'b1; msb_first = 1'b1;
        clr = 1'b0; async_sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state despite active inputs
        check("R1 stage", stage_q, '0);
        check("R1 word", word_q, '0);
        check("R1 vld", W'(word_vld), '0);
        shift_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // vector walk: every word must come out as sent (R2, R3, R5, R6, R9)
        for (int v = 0; v < 8; v++) begin
            send_word(VEC[v][W-1:0], VEC[v][W], VEC[v][W+1]);
            check(VEC[v][W] ? "R2 assembled" : "R3 assembled", stage_q, VEC[v][W-1:0]);
            check("R5 strobe high", W'(word_vld), W'(1));
            check("R6 word latched", word_q, VEC[v][W-1:0]);
            @(negedge clk);
            check("R5 strobe one cycle", W'(word_vld), '0);
        end

        // R2/R4: first bit placement, msb-first
        async_sel = 1'b0;
        pulse_clr();
        msb_first = 1'b1;
        put_bit(1'b1, 1'b0);
        check("R4 R2 first bit at bit0", stage_q, 8'h01);
        put_bit(1'b0, 1'b0);
        check("R2 moved up", stage_q, 8'h02);

        // R3: first bit placement, lsb-first
        pulse_clr();
        msb_first = 1'b0;
        put_bit(1'b1, 1'b0);
        check("R3 first bit at MSB", stage_q, 8'h80);
        put_bit(1'b1, 1'b0);
        check("R3 moved down", stage_q, 8'hC0);

        // R7: hold with shift_en low, then finish the word
        pulse_clr();
        msb_first = 1'b1;
        put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0); put_bit(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            ser_in = k[0];
            @(negedge clk);
        end
        check("R7 stages held", stage_q, 8'h05);
        check("R7 no strobe", W'(word_vld), '0);
        put_bit(1'b1, 1'b0); put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0);
        put_bit(1'b0, 1'b0);
        check("R7 count held", W'(word_vld), '0);
        put_bit(1'b1, 1'b0);
        check("R7 word after pause", W'(word_vld), W'(1));
        check("R7 word value", word_q, 8'hB9);

        // R6: held word steady while next word shifts
        put_bit(1'b1, 1'b0); put_bit(1'b1, 1'b0); put_bit(1'b1, 1'b0);
        check("R6 stages moving", stage_q, 8'hCF);
        check("R6 word steady", word_q, 8'hB9);

        // R8: clear beats shift, keeps word, restarts count
        pulse_clr();
        put_bit(1'b1, 1'b0); put_bit(1'b1, 1'b0); put_bit(1'b1, 1'b0);
        ser_in = 1'b1; shift_en = 1'b1; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; shift_en = 1'b0;
        check("R8 stages zero", stage_q, '0);
        check("R8 no strobe", W'(word_vld), '0);
        check("R8 word kept", word_q, 8'hB9);
        for (int k = 0; k < W - 1; k++) put_bit(1'b1, 1'b0);
        check("R8 count restarted", W'(word_vld), '0);
        check("R8 partial", stage_q, 8'h7F);
        put_bit(1'b1, 1'b0);
        check("R8 full word", word_q, 8'hFF);

        // R9: synchronized path takes the bit from two edges earlier
        pulse_clr();
        async_sel = 1'b1; msb_first = 1'b1; ser_in = 1'b0;
        repeat (3) @(negedge clk);
        ser_in = 1'b1; shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        check("R9 old bit taken", stage_q, 8'h00);
        @(negedge clk);
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        check("R9 delayed bit", stage_q, 8'h01);
        // R9: direct path takes the current bit
        pulse_clr();
        async_sel = 1'b0; ser_in = 1'b0;
        repeat (3) @(negedge clk);
        ser_in = 1'b1; shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        check("R9 direct bit", stage_q, 8'h01);

        done = 1;
        finish_run();
    end
endmodule